// File: doc/BRIEF.md
# Two-Port Memory with Same-Word Collision Arbitration

This block is a two-port word memory (left and right) with a hardware detector for the case where both sides select the same word in the same cycle. Each port has a chip enable, a word address, a write enable, write data, registered read data, and an active-low busy signal. Busy is carried on two pins per port: one driven by the block and one sampled by it. Reads and writes on the two ports are otherwise independent, and neither port slows the other.

A strap input chooses the role. In master mode the block decides which side wins a collision. It drives busy low to the losing side and suppresses that side's write internally. The decision depends only on enables and addresses, never on read versus write. In slave mode the block makes no decision: its busy outputs stay high, and each busy input acts only as a write inhibit for its own port. Several slaves can therefore follow one master and no word is ever split between two decisions. All ports here are plain control and data pins with no valid/ready handshake, because a memory access completes in a fixed cycle and is never back-pressured.

Top module: `dp_collide_ram`

## Requirements
- R1: After reset, both busy outputs are high and both read-data outputs are zero.
- R2: In master mode a collision exists only while both chip enables are high and the two addresses are equal. With no collision, both busy outputs are high in the same cycle.
- R3: In master mode, if both ports begin selecting the same word in the same cycle, the left port wins. Right busy goes low combinationally in that cycle and left busy stays high.
- R4: In master mode, a port that was already enabled on the word in the previous cycle keeps priority over a newcomer. While the collision continues unchanged, the winner does not change.
- R5: The write enables have no effect on which port is flagged busy.
- R6: In master mode, a write from the port whose busy output is low leaves the memory unchanged. The winner's write in the same cycle is stored.
- R7: A port flagged busy still reads. Its read data, registered one clock after the address, shows the stored word.
- R8: In slave mode, both busy outputs are high at all times. With a port's busy input high (1), that port writes normally.
- R9: In slave mode, a port whose busy input is low (0) has every write blocked. Its reads still work.
- R10: If both ports write the same word in the same cycle with neither write inhibited (possible only in slave mode), the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and read-data registers update on its rising edge |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1 = master (arbitrates), 0 = slave (busy inputs inhibit writes) |
| l_ce | input | 1 | Left chip enable, active high |
| l_addr | input | AW | Left word address |
| l_we | input | 1 | Left write enable, active high |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, registered |
| l_busy_n_i | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_o | output | 1 | Left busy in master mode, active low, driven both levels |
| r_ce | input | 1 | Right chip enable, active high |
| r_addr | input | AW | Right word address |
| r_we | input | 1 | Right write enable, active high |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, registered |
| r_busy_n_i | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_o | output | 1 | Right busy in master mode, active low, driven both levels |

## Verification
The hardest situation to reach is the incumbent case. The right port must already be sitting on a word when the left port arrives on the same word, so that the usual left-wins rule is overridden and the left side loses. The bench sets this up by enabling only the right port for one full clock and then enabling the left port on the same address. In that cycle it issues conflicting writes from both sides and checks that only the right port's data lands. It then reads the word back through the losing port while the collision is still held.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic {WIN_LEFT = 1'b0, WIN_RIGHT = 1'b1} win_e;
  localparam int NPORT = 2;
endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce,
  input  logic [AW-1:0] r_addr,
  output logic          coll,
  output win_e          winner
);
  logic          l_ce_q, r_ce_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  win_e          win_q;
  logic          l_held, r_held;

  assign coll   = l_ce && r_ce && (l_addr == r_addr);
  assign l_held = l_ce && l_ce_q && (l_addr_q == l_addr);
  assign r_held = r_ce && r_ce_q && (r_addr_q == r_addr);

  // priority: continuing collision keeps old winner, incumbent beats newcomer, tie -> left
  always_comb begin
    if (l_held && r_held)  winner = win_q;
    else if (r_held)       winner = WIN_RIGHT;
    else                   winner = WIN_LEFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_ce_q   <= 1'b0;
      r_ce_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      win_q    <= WIN_LEFT;
    end else begin
      l_ce_q   <= l_ce;
      r_ce_q   <= r_ce;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      win_q    <= coll ? winner : WIN_LEFT;
    end
  end
endmodule

// File: rtl/dpc_wgate.sv
module dpc_wgate (
  input  logic master_mode,
  input  logic ce,
  input  logic we,
  input  logic busy_n_own,
  input  logic busy_n_ext,
  output logic wr_en
);
  logic allow;
  assign allow = master_mode ? busy_n_own : busy_n_ext;
  assign wr_en = ce && we && allow;
endmodule

// File: rtl/dpc_array.sv
module dpc_array #(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ce,
  input  logic [1:0][AW-1:0]  addr,
  input  logic [1:0]          wr_en,
  input  logic [1:0][DW-1:0]  wdata,
  output logic [1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // right first, left last: left wins an unblocked same-word double write
  always_ff @(posedge clk) begin
    if (wr_en[1]) mem[addr[1]] <= wdata[1];
    if (wr_en[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[p] <= '0;
      else if (ce[p]) rdata[p] <= mem[addr[p]];
    end
  end
endmodule

// File: rtl/dp_collide_ram.sv
module dp_collide_ram
  import dpc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_ce,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_n_i,
  output logic          l_busy_n_o,
  input  logic          r_ce,
  input  logic [AW-1:0] r_addr,
  input  logic          r_we,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_n_i,
  output logic          r_busy_n_o
);
  logic                   coll;
  win_e                   winner;
  logic [1:0]             ce_v, we_v, bo_v, bi_v, wr_en;
  logic [1:0][AW-1:0]     addr_v;
  logic [1:0][DW-1:0]     wd_v, rd_v;

  dpc_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_addr(l_addr),
    .r_ce(r_ce), .r_addr(r_addr),
    .coll(coll), .winner(winner)
  );

  assign l_busy_n_o = !(master_mode && coll && winner == WIN_RIGHT);
  assign r_busy_n_o = !(master_mode && coll && winner == WIN_LEFT);

  assign ce_v   = {r_ce, l_ce};
  assign we_v   = {r_we, l_we};
  assign bo_v   = {r_busy_n_o, l_busy_n_o};
  assign bi_v   = {r_busy_n_i, l_busy_n_i};
  assign addr_v = {r_addr, l_addr};
  assign wd_v   = {r_wdata, l_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_gate
    dpc_wgate u_gate (
      .master_mode(master_mode), .ce(ce_v[p]), .we(we_v[p]),
      .busy_n_own(bo_v[p]), .busy_n_ext(bi_v[p]), .wr_en(wr_en[p])
    );
  end

  dpc_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .ce(ce_v), .addr(addr_v),
    .wr_en(wr_en), .wdata(wd_v), .rdata(rd_v)
  );

  assign l_rdata = rd_v[0];
  assign r_rdata = rd_v[1];
endmodule

// File: rtl/dpc_chk.sv
module dpc_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          l_ce,
  input logic [AW-1:0] l_addr,
  input logic          r_ce,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_n_i,
  input logic          r_busy_n_i,
  input logic          l_busy_n_o,
  input logic          r_busy_n_o,
  input logic          l_wr,
  input logic          r_wr
);
  logic same, vld;
  assign same = l_ce && r_ce && (l_addr == r_addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld <= 1'b0; else vld <= 1'b1;

  // R2
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !same) |-> (l_busy_n_o && r_busy_n_o));
  // R3
  p_one_loser_r3: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && same |-> (l_busy_n_o != r_busy_n_o));
  // R4
  p_keep_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && master_mode && same && $past(master_mode) && $past(same)
     && $past(l_addr) == l_addr) |-> $stable(l_busy_n_o));
  // R6
  p_loser_no_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> ((l_busy_n_o || !l_wr) && (r_busy_n_o || !r_wr)));
  // R8
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n_o && r_busy_n_o));
  // R9
  p_slave_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> ((l_busy_n_i || !l_wr) && (r_busy_n_i || !r_wr)));
endmodule

bind dp_collide_ram dpc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .l_ce(l_ce), .l_addr(l_addr), .r_ce(r_ce), .r_addr(r_addr),
  .l_busy_n_i(l_busy_n_i), .r_busy_n_i(r_busy_n_i),
  .l_busy_n_o(l_busy_n_o), .r_busy_n_o(r_busy_n_o),
  .l_wr(wr_en[0]), .r_wr(wr_en[1])
);

// File: tb/sim_dp_collide_ram.sv
`timescale 1ns/1ps
module sim_dp_collide_ram;
  localparam int AW = 10;
  localparam int DW = 18;

  logic clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1;
  logic l_ce = 0, r_ce = 0, l_we = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  logic l_busy_n_i = 1, r_busy_n_i = 1, l_busy_n_o, r_busy_n_o;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  dp_collide_ram #(.AW(AW), .DW(DW)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    l_ce = 0; r_ce = 0; l_we = 0; r_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 l_busy", l_busy_n_o, 1); chk("R1 r_busy", r_busy_n_o, 1);
    chk("R1 l_rdata", l_rdata, 0);   chk("R1 r_rdata", r_rdata, 0);
  endtask

  task automatic t_nocoll();
    idle();
    l_ce = 1; r_ce = 1; l_addr = 5; r_addr = 6; #1;
    chk("R2 diff addr l", l_busy_n_o, 1); chk("R2 diff addr r", r_busy_n_o, 1);
    @(negedge clk);
    r_ce = 0; r_addr = 5; #1;
    chk("R2 one ce l", l_busy_n_o, 1); chk("R2 one ce r", r_busy_n_o, 1);
  endtask

  task automatic t_tie();
    idle(); idle();
    l_ce = 1; r_ce = 1; l_addr = 7; r_addr = 7;
    l_we = 1; r_we = 1; l_wdata = 18'h000AA; r_wdata = 18'h000BB; #1;
    chk("R3 tie left high", l_busy_n_o, 1); chk("R3 tie right low", r_busy_n_o, 0);
    @(negedge clk);
    l_we = 0; r_we = 0; #1;
    chk("R5 we off l", l_busy_n_o, 1); chk("R5 we off r", r_busy_n_o, 0);
    @(negedge clk);
    chk("R6 R7 loser reads winner data", r_rdata, 18'h000AA);
    chk("R7 winner read", l_rdata, 18'h000AA);
    r_we = 1; r_wdata = 18'h3FFFF; #1;
    chk("R5 right we l", l_busy_n_o, 1); chk("R5 right we r", r_busy_n_o, 0);
    @(negedge clk); r_we = 0;
    @(negedge clk);
    chk("R6 loser write blocked", r_rdata, 18'h000AA);
  endtask

  task automatic t_incumbent();
    idle(); idle();
    r_ce = 1; r_addr = 9;
    @(negedge clk);
    l_ce = 1; l_addr = 9; l_we = 1; r_we = 1;
    l_wdata = 18'h00111; r_wdata = 18'h00222; #1;
    chk("R4 newcomer left low", l_busy_n_o, 0); chk("R4 incumbent right high", r_busy_n_o, 1);
    @(negedge clk);
    l_we = 0; r_we = 0; #1;
    chk("R4 held winner", l_busy_n_o, 0);
    @(negedge clk);
    chk("R6 R7 loser left read", l_rdata, 18'h00222);
    chk("R4 still held", l_busy_n_o, 0);
  endtask

  task automatic t_slave();
    idle();
    master_mode = 0; l_busy_n_i = 1; r_busy_n_i = 1;
    l_ce = 1; r_ce = 1; l_addr = 20; r_addr = 20; l_we = 1; r_we = 1;
    l_wdata = 18'h0AAAA; r_wdata = 18'h05555; #1;
    chk("R8 slave busy l", l_busy_n_o, 1); chk("R8 slave busy r", r_busy_n_o, 1);
    @(negedge clk);
    l_we = 0; r_we = 0;
    @(negedge clk);
    chk("R10 left data kept", r_rdata, 18'h0AAAA);
    r_we = 1; r_addr = 21; r_wdata = 18'h01234;
    @(negedge clk); r_we = 0;
    @(negedge clk);
    chk("R8 normal slave write", r_rdata, 18'h01234);
    l_busy_n_i = 0; l_we = 1; l_wdata = 18'h3FFFF;
    r_busy_n_i = 0; #1;
    chk("R8 busy out ignores inputs", l_busy_n_o, 1);
    @(negedge clk); l_we = 0;
    @(negedge clk);
    chk("R9 inhibited write", l_rdata, 18'h0AAAA);
    l_addr = 21;
    @(negedge clk);
    chk("R9 inhibited port reads", l_rdata, 18'h01234);
    l_busy_n_i = 1; r_busy_n_i = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_nocoll();
    t_tie();
    t_incumbent();
    t_slave();
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule